// File: doc/BRIEF.md
# Snooping Coherence Line Controller

This block is the processor-facing state machine that tracks one cache line under a snooping protocol with six stable states: Modified, Owned, Exclusive, Shared, Invalid and Forward. The processor presents load and store requests. A hit is answered with a one-cycle response pulse. A miss or a write upgrade puts a read-shared or read-for-ownership request on the shared bus. The line then waits in a transient state until the bus returns data. Every bus request made for a processor access counts as a miss, and this includes upgrades from lines that already hold valid data.

Requests seen on the bus from other caches are handled only as far as the line itself needs. They can invalidate or downgrade a stable copy, and they tell the snooping logic whether this cache supplies the data or holds a shared copy. The data array, bus arbitration and memory are outside the block. They appear only as valid/ready style signals.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (`line_state` 0), `miss_count` and `err_flag` are 0, `bus_req_valid` and `resp_valid` are low, and `req_ready` is high. The `line_state` encoding is I=0, S=1, E=2, O=3, F=4, M=5, IS=8, IM=9, SM=10, OM=11, FM=12, so bit 3 marks a transient state.
- R2: In Invalid, an accepted load (`req_op` 0) captures `req_addr` as the line address and enters IS. It increments `miss_count`, and from the next cycle it drives `bus_req_valid` with `bus_req_getm` 0 and `bus_req_addr` equal to the captured address.
- R3: In Invalid, an accepted store (`req_op` 1) captures the address and enters IM. It increments `miss_count` and requests the bus with `bus_req_getm` 1.
- R4: A load in S, E, O, F or M, and a store in M, is a hit. `resp_valid` pulses in the cycle after acceptance, with no bus request and no change to `miss_count` or state. A store in E moves the line to M with the same hit response, without any bus request or miss.
- R5: A store in S, O or F enters SM, OM or FM respectively. It issues a request with `bus_req_getm` 1 and increments `miss_count`.
- R6: In a transient state, `bus_req_valid` stays high until a cycle with `bus_req_ready`. `bus_data_valid` is honoured only after that grant. On data, IS settles to S if `bus_shared` is high and to E otherwise, and IM, SM, OM and FM settle to M. `resp_valid` pulses in the following cycle.
- R7: `req_ready` is low in every transient state and in any cycle with `snp_valid` high, so at most one request is outstanding.
- R8: An accepted request with `req_op` 2 or 3 sets `err_flag`, which stays set until reset. Such a request changes neither state nor `miss_count` and gives no response.
- R9: A snooped read-for-ownership (`snp_getm` 1) whose `snp_addr` matches the line, in any valid stable state, sends the line to Invalid. `snp_supply` is high in that cycle when the state is M, O or F.
- R10: A matching snooped read-shared (`snp_getm` 0) in a valid stable state raises `snp_shared`. It moves M to O and E to F and leaves S, O and F unchanged. `snp_supply` is high in M, O and F but not in E or S.
- R11: A snoop has no effect and raises neither `snp_supply` nor `snp_shared` when its address differs from the line address, when the line is Invalid, or when the line is in a transient state.
- R12: `miss_count` is CNT_W bits wide (32 by default) and holds at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 and 3 illegal |
| req_addr | input | AW | Request line address |
| resp_valid | output | 1 | One-cycle completion pulse to the processor |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_ready | input | 1 | Bus grant for the pending request |
| bus_req_getm | output | 1 | 1 read-for-ownership, 0 read-shared |
| bus_req_addr | output | AW | Address of the bus request |
| bus_data_valid | input | 1 | Data response for this line's request |
| bus_shared | input | 1 | Another cache holds the line, sampled with data |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_getm | input | 1 | Snooped request is read-for-ownership |
| snp_addr | input | AW | Snooped request address |
| snp_supply | output | 1 | This cache supplies data for the snoop |
| snp_shared | output | 1 | This cache keeps a copy after the snoop |
| line_state | output | 4 | Current coherence state |
| miss_count | output | CNT_W | Saturating miss counter |
| err_flag | output | 1 | Sticky illegal-request flag |

## Verification
The bench targets the upgrade paths from S, O and F. A design that treated these as silent hits would show no bus request and an unchanged miss count. It also checks the silent E-to-M store, where a wrong design would spend a bus transaction and a miss. Data arriving before the grant is driven deliberately, because a controller that accepted it would leave the transient state early. Other tests cover snoops against a transient or Invalid line, and against a different address, where a careless design would corrupt the state. The saturation test uses a narrow counter and pushes it past its maximum, which exposes a counter that wraps to zero.

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl #(
  parameter int AW    = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  output logic             resp_valid,
  output logic             bus_req_valid,
  input  logic             bus_req_ready,
  output logic             bus_req_getm,
  output logic [AW-1:0]    bus_req_addr,
  input  logic             bus_data_valid,
  input  logic             bus_shared,
  input  logic             snp_valid,
  input  logic             snp_getm,
  input  logic [AW-1:0]    snp_addr,
  output logic             snp_supply,
  output logic             snp_shared,
  output logic [3:0]       line_state,
  output logic [CNT_W-1:0] miss_count,
  output logic             err_flag
);
  localparam logic [3:0] ST_I  = 4'd0;
  localparam logic [3:0] ST_S  = 4'd1;
  localparam logic [3:0] ST_E  = 4'd2;
  localparam logic [3:0] ST_O  = 4'd3;
  localparam logic [3:0] ST_F  = 4'd4;
  localparam logic [3:0] ST_M  = 4'd5;
  localparam logic [3:0] ST_IS = 4'd8;
  localparam logic [3:0] ST_IM = 4'd9;
  localparam logic [3:0] ST_SM = 4'd10;
  localparam logic [3:0] ST_OM = 4'd11;
  localparam logic [3:0] ST_FM = 4'd12;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]    st, nxt;
  logic [AW-1:0] tag;
  logic          sent, resp_q, err_q;
  logic [CNT_W-1:0] misses;
  logic          miss_inc, hit, bad;

  wire transient  = st[3];
  wire valid_line = !st[3] && (st != ST_I);
  wire owner_like = (st == ST_M) || (st == ST_O) || (st == ST_F);
  wire snp_hit    = snp_valid && valid_line && (snp_addr == tag);
  wire is_load    = (req_op == 2'd0);
  wire is_store   = (req_op == 2'd1);

  assign req_ready     = !transient && !snp_valid;
  wire   accept        = req_valid && req_ready;
  assign bus_req_valid = transient && !sent;
  assign bus_req_getm  = (st != ST_IS);
  assign bus_req_addr  = tag;
  wire   data_in       = transient && sent && bus_data_valid;
  assign snp_supply    = snp_hit && owner_like;
  assign snp_shared    = snp_hit && !snp_getm;

  assign line_state = st;
  assign miss_count = misses;
  assign err_flag   = err_q;
  assign resp_valid = resp_q;

  always_comb begin
    nxt      = st;
    miss_inc = 1'b0;
    hit      = 1'b0;
    bad      = 1'b0;
    if (snp_hit) begin
      if (snp_getm)         nxt = ST_I;
      else if (st == ST_M)  nxt = ST_O;
      else if (st == ST_E)  nxt = ST_F;
    end else if (data_in) begin
      if (st == ST_IS) nxt = bus_shared ? ST_S : ST_E;
      else             nxt = ST_M;
    end else if (accept) begin
      if (!(is_load || is_store)) begin
        bad = 1'b1;
      end else begin
        case (st)
          ST_I: begin
            nxt      = is_load ? ST_IS : ST_IM;
            miss_inc = 1'b1;
          end
          ST_S, ST_O, ST_F: begin
            if (is_load) begin
              hit = 1'b1;
            end else begin
              miss_inc = 1'b1;
              nxt = (st == ST_S) ? ST_SM : (st == ST_O) ? ST_OM : ST_FM;
            end
          end
          ST_E: begin
            hit = 1'b1;
            if (is_store) nxt = ST_M;
          end
          ST_M:    hit = 1'b1;
          default: bad = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_I;
      tag    <= '0;
      sent   <= 1'b0;
      resp_q <= 1'b0;
      err_q  <= 1'b0;
      misses <= '0;
    end else begin
      st     <= nxt;
      resp_q <= hit || data_in;
      err_q  <= err_q || bad;
      if (accept && st == ST_I) tag <= req_addr;
      if (bus_req_valid && bus_req_ready) sent <= 1'b1;
      else if (data_in)                  sent <= 1'b0;
      if (miss_inc && misses != CNT_MAX) misses <= misses + 1'b1;
    end
  end
endmodule

module snoop_line_ctrl_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_op,
  input logic [3:0]       line_state,
  input logic             bus_req_valid,
  input logic             snp_supply,
  input logic             err_flag,
  input logic [CNT_W-1:0] miss_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_state[3] |-> !req_ready);

  assert_bus_only_transient_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> line_state[3]);

  assert_supply_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (line_state == 4'd5 || line_state == 4'd3 || line_state == 4'd4));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_cnt_saturates_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == TOP) |=> (miss_count == TOP));

  assert_load_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'd0 && line_state == 4'd0) |=> (line_state == 4'd8));
endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/snoop_line_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_line_ctrl_tb;
  localparam int AW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, bus_req_ready = 0, bus_data_valid = 0, bus_shared = 0;
  logic snp_valid = 0, snp_getm = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, snp_addr = 0;
  logic req_ready, resp_valid, bus_req_valid, bus_req_getm, snp_supply, snp_shared, err_flag;
  logic [AW-1:0] bus_req_addr;
  logic [3:0] line_state;
  logic [CW-1:0] miss_count;

  int n_run = 0, n_fail = 0, exp_miss = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  snoop_line_ctrl #(.AW(AW), .CNT_W(CW)) u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int sat(int v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic request(logic [1:0] op, logic [AW-1:0] a);
    req_valid = 1; req_op = op; req_addr = a;
    step();
    req_valid = 0;
  endtask

  task automatic complete(bit shared, logic [3:0] exp_state, string tag);
    bus_req_ready = 1;
    step();
    bus_req_ready = 0;
    check({tag, " bus released after grant"}, bus_req_valid, 0);
    bus_data_valid = 1; bus_shared = shared;
    step();
    bus_data_valid = 0; bus_shared = 0;
    check({tag, " settled state"}, line_state, exp_state);
    check({tag, " resp after data"}, resp_valid, 1);
    check({tag, " ready again"}, req_ready, 1);
  endtask

  task automatic snoop(bit getm, logic [AW-1:0] a, bit exp_sup, bit exp_sh,
                       logic [3:0] exp_state, string tag);
    snp_valid = 1; snp_getm = getm; snp_addr = a;
    #1;
    check({tag, " supply"}, snp_supply, exp_sup);
    check({tag, " shared"}, snp_shared, exp_sh);
    check({tag, " ready low on snoop (R7)"}, req_ready, 0);
    step();
    snp_valid = 0;
    check({tag, " state"}, line_state, exp_state);
  endtask

  task automatic t_reset();
    check("R1 state", line_state, 0);
    check("R1 miss", miss_count, 0);
    check("R1 err", err_flag, 0);
    check("R1 bus idle", bus_req_valid, 0);
    check("R1 resp idle", resp_valid, 0);
    check("R1 ready", req_ready, 1);
  endtask

  task automatic t_load_exclusive();
    request(2'd0, 8'hA5); exp_miss++;
    check("R2 IS", line_state, 8);
    check("R2 miss", miss_count, sat(exp_miss));
    check("R2 bus valid", bus_req_valid, 1);
    check("R2 gets", bus_req_getm, 0);
    check("R2 addr", bus_req_addr, 8'hA5);
    check("R7 ready low", req_ready, 0);
    step();
    check("R6 bus held", bus_req_valid, 1);
    bus_data_valid = 1; step(); bus_data_valid = 0;
    check("R6 early data ignored", line_state, 8);
    complete(0, 2, "R6 IS->E");
    request(2'd0, 8'hA5);
    check("R4 E load resp", resp_valid, 1);
    check("R4 E load state", line_state, 2);
    request(2'd1, 8'hA5);
    check("R4 E store to M", line_state, 5);
    check("R4 E store resp", resp_valid, 1);
    check("R4 E store no bus", bus_req_valid, 0);
    check("R4 E store no miss", miss_count, sat(exp_miss));
  endtask

  task automatic t_owned();
    snoop(0, 8'hA5, 1, 1, 3, "R10 M gets");
    request(2'd0, 8'hA5);
    check("R4 O load resp", resp_valid, 1);
    request(2'd1, 8'hA5); exp_miss++;
    check("R5 OM", line_state, 11);
    check("R5 OM getm", bus_req_getm, 1);
    check("R5 OM miss", miss_count, sat(exp_miss));
    complete(0, 5, "R6 OM->M");
    request(2'd1, 8'hA5);
    check("R4 M store resp", resp_valid, 1);
    check("R4 M store miss", miss_count, sat(exp_miss));
    snoop(0, 8'hA5, 1, 1, 3, "R10 M gets again");
    snoop(1, 8'h11, 0, 0, 3, "R11 other addr");
    snoop(1, 8'hA5, 1, 0, 0, "R9 O getm");
  endtask

  task automatic t_store_shared();
    snoop(1, 8'hA5, 0, 0, 0, "R11 in I");
    request(2'd1, 8'h3C); exp_miss++;
    check("R3 IM", line_state, 9);
    check("R3 getm", bus_req_getm, 1);
    check("R3 addr", bus_req_addr, 8'h3C);
    check("R3 miss", miss_count, sat(exp_miss));
    complete(1, 5, "R6 IM->M");
    snoop(1, 8'h3C, 1, 0, 0, "R9 M getm");
    request(2'd0, 8'h3C); exp_miss++;
    snoop(1, 8'h3C, 0, 0, 8, "R11 transient");
    complete(1, 1, "R6 IS->S");
    snoop(0, 8'h3C, 0, 1, 1, "R10 S gets");
    request(2'd0, 8'h3C);
    check("R4 S load resp", resp_valid, 1);
    check("R4 S no bus", bus_req_valid, 0);
    request(2'd1, 8'h3C); exp_miss++;
    check("R5 SM", line_state, 10);
    check("R5 SM miss", miss_count, sat(exp_miss));
    complete(0, 5, "R6 SM->M");
  endtask

  task automatic t_forward();
    snoop(1, 8'h3C, 1, 0, 0, "R9 clear");
    request(2'd0, 8'h77); exp_miss++;
    complete(0, 2, "R6 to E");
    snoop(0, 8'h77, 0, 1, 4, "R10 E gets");
    request(2'd0, 8'h77);
    check("R4 F load resp", resp_valid, 1);
    snoop(0, 8'h77, 1, 1, 4, "R10 F gets");
    request(2'd1, 8'h77); exp_miss++;
    check("R5 FM", line_state, 12);
    check("R5 FM miss", miss_count, sat(exp_miss));
    complete(0, 5, "R6 FM->M");
  endtask

  task automatic t_illegal();
    request(2'd2, 8'h77);
    check("R8 err set", err_flag, 1);
    check("R8 state kept", line_state, 5);
    check("R8 no resp", resp_valid, 0);
    check("R8 miss kept", miss_count, sat(exp_miss));
    request(2'd3, 8'h77);
    step(); step();
    check("R8 err sticky", err_flag, 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 14; i++) begin
      snoop(1, 8'h77, (line_state == 5), 0, 0, "R12 inval");
      request(2'd1, 8'h77); exp_miss++;
      complete(0, 5, "R12 refill");
    end
    check("R12 saturated", miss_count, 15);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_load_exclusive();
    t_owned();
    t_store_shared();
    t_forward();
    t_illegal();
    t_saturate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule